// File: doc/BRIEF.md
# Bit-Operation and Condition Unit

This unit sits beside a processor's register file. It holds the processor's single condition bit and does bit-level work on register values. Each operation takes two register values that were read earlier: a target word and a second word. The second word is either a bit index or the other operand of a comparison. From these the unit produces a result word with a write-back enable, or it loads the condition bit. Conditional jumps read that bit from the `cond_flag` output.

There are four bit operations:

- Set a bit.
- Clear a bit.
- Copy a bit into the condition.
- Set a bit only when the condition is true. This last one never clears the bit.

There are four tests, which load the condition bit:

- Target equals zero.
- Target is non-zero.
- Second operand is above the target.
- Second operand is at or below the target.

The result path is combinational and is valid in the same cycle as the operation. The condition bit is a register that takes its new value at the clock edge that ends the operation's cycle. `WIDTH` must be a power of two of at least 2.

Top module: `bitcond_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `cond_flag` is 0 until the first test or bit-get operation.
- R2: Code 0 (set) with `op_valid` high drives `res_we`=1 and `res_data` = `tgt_val` OR (1 shifted left by the bit index).
- R3: Code 1 (clear) with `op_valid` high drives `res_we`=1 and `res_data` = `tgt_val` AND NOT (1 shifted left by the bit index).
- R4: Code 2 (get) drives `res_we`=0 and loads `cond_flag` with the indexed bit of `tgt_val` at the next clock edge.
- R5: Code 3 (put) with `cond_flag`=1 behaves like set. With `cond_flag`=0 it drives `res_we`=0 and `res_data`=`tgt_val`, so the target is left unchanged.
- R6: Code 4 loads `cond_flag` with (`tgt_val`==0). Code 5 loads it with (`tgt_val`!=0).
- R7: Code 6 loads `cond_flag` with (`src_val` > `tgt_val`). Code 7 loads it with (`src_val` <= `tgt_val`). Both comparisons are unsigned. Tests drive `res_we`=0.
- R8: The bit index is `src_val` modulo `WIDTH`, that is, its low log2(`WIDTH`) bits.
- R9: `cond_flag` keeps its value when `op_valid` is low, and under codes 0, 1, 3 and 8 to 15.
- R10: `res_we` is 0 whenever `op_valid` is low or the code is 8 to 15. Whenever `res_we` is 0, `res_data` equals `tgt_val`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation enable for this cycle |
| op_code | input | 4 | Operation code (0 to 7 defined) |
| tgt_val | input | WIDTH | Target register value / first operand |
| src_val | input | WIDTH | Bit index / second operand |
| res_data | output | WIDTH | Result word for write-back |
| res_we | output | 1 | Write-back enable |
| cond_flag | output | 1 | Current condition bit |

## Verification
The bench drives inputs on the falling clock edge. `res_data` and `res_we` depend only on the inputs and the present condition, so the bench checks them 2 ns after driving, in the same cycle and before the rising edge. The condition update lands on the rising edge that closes the operation's cycle. The bench checks `cond_flag` at the next falling edge, before it drives the next operation. Bit-put is therefore always judged against the condition that the previous operation left behind.

// File: rtl/bitcond_unit.sv
module bitcond_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [3:0]       op_code,
  input  logic [WIDTH-1:0] tgt_val,
  input  logic [WIDTH-1:0] src_val,
  output logic [WIDTH-1:0] res_data,
  output logic             res_we,
  output logic             cond_flag
);
  localparam int IDXW = $clog2(WIDTH);
  localparam logic [3:0] OP_SET = 4'd0, OP_CLR = 4'd1, OP_GET = 4'd2, OP_PUT = 4'd3,
                         OP_TZ  = 4'd4, OP_TNZ = 4'd5, OP_TC  = 4'd6, OP_TNC = 4'd7;

  logic [IDXW-1:0]  bit_idx;
  logic [WIDTH-1:0] bit_mask;
  logic             do_or, do_clr, cond_load, cond_next;

  assign bit_idx  = src_val[IDXW-1:0];
  assign bit_mask = {{(WIDTH-1){1'b0}}, 1'b1} << bit_idx;

  assign do_or  = op_valid & ((op_code == OP_SET) | ((op_code == OP_PUT) & cond_flag));
  assign do_clr = op_valid & (op_code == OP_CLR);

  assign res_we   = do_or | do_clr;
  assign res_data = do_or ? (tgt_val | bit_mask) : do_clr ? (tgt_val & ~bit_mask) : tgt_val;

  always_comb begin
    cond_load = op_valid;
    cond_next = cond_flag;
    case (op_code)
      OP_GET:  cond_next = tgt_val[bit_idx];
      OP_TZ:   cond_next = (tgt_val == '0);
      OP_TNZ:  cond_next = (tgt_val != '0);
      OP_TC:   cond_next = (src_val > tgt_val);
      OP_TNC:  cond_next = (src_val <= tgt_val);
      default: cond_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cond_flag <= 1'b0;
    else if (cond_load) cond_flag <= cond_next;
  end

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> !cond_flag);

  a_r2_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_SET) |-> (res_we && res_data[bit_idx] && ((res_data & tgt_val) == tgt_val)));

  a_r3_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CLR) |-> (res_we && !res_data[bit_idx] && ((res_data | tgt_val) == tgt_val)));

  a_r4_get_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_GET) |=> (cond_flag == $past(tgt_val[src_val[IDXW-1:0]])));

  a_r5_put_false: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_PUT && !cond_flag) |-> (!res_we && res_data == tgt_val));

  a_r6_zero_test: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_TZ) |=> (cond_flag == ($past(tgt_val) == '0)));

  a_r7_carry_test: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_TC) |=> (cond_flag == ($past(src_val) > $past(tgt_val))));

  a_r9_cond_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_code == OP_SET || op_code == OP_CLR || op_code == OP_PUT || op_code[3])
      |=> $stable(cond_flag));

  a_r10_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_code[3]) |-> (!res_we && res_data == tgt_val));
endmodule

// File: tb/bitcond_unit_tb.sv
module bitcond_unit_tb;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic [W-1:0] tgt_val = '0, src_val = '0, res_data;
  logic res_we, cond_flag;
  int n_vec = 0, n_bad = 0;
  logic m_cond = 1'b0;

  always #4 clk = ~clk;

  bitcond_unit #(.WIDTH(W)) u_dut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .tgt_val(tgt_val), .src_val(src_val), .res_data(res_data), .res_we(res_we), .cond_flag(cond_flag));

  function automatic logic [W-1:0] mask_of(logic [W-1:0] b);
    return 32'd1 << (b % W);
  endfunction

  function automatic logic exp_we(logic v, logic [3:0] c, logic k);
    return v && (c == 0 || c == 1 || (c == 3 && k));
  endfunction

  function automatic logic [W-1:0] exp_res(logic v, logic [3:0] c, logic [W-1:0] a, logic [W-1:0] b, logic k);
    if (v && (c == 0 || (c == 3 && k))) return a | mask_of(b);
    if (v && c == 1) return a & ~mask_of(b);
    return a;
  endfunction

  function automatic logic exp_cond(logic v, logic [3:0] c, logic [W-1:0] a, logic [W-1:0] b, logic k);
    if (!v) return k;
    case (c)
      4'd2: return a[b % W];
      4'd4: return a == 0;
      4'd5: return a != 0;
      4'd6: return b > a;
      4'd7: return b <= a;
      default: return k;
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag_of(logic [3:0] c);
    case (c)
      4'd0: return "R2 set";
      4'd1: return "R3 clear";
      4'd2: return "R4 get";
      4'd3: return "R5 put";
      4'd4, 4'd5: return "R6 zero test";
      4'd6, 4'd7: return "R7 carry test";
      default: return "R10 unused code";
    endcase
  endfunction

  task automatic apply(logic v, logic [3:0] c, logic [W-1:0] a, logic [W-1:0] b, string req);
    @(negedge clk);
    check({req, " cond before"}, {31'd0, cond_flag}, {31'd0, m_cond});
    op_valid = v; op_code = c; tgt_val = a; src_val = b;
    #2;
    check({req, " we"}, {31'd0, res_we}, {31'd0, exp_we(v, c, m_cond)});
    check({req, " data"}, res_data, exp_res(v, c, a, b, m_cond));
    m_cond = exp_cond(v, c, a, b, m_cond);
    @(posedge clk);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 check("R1 reset cond", {31'd0, cond_flag}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk) check("R1 after release", {31'd0, cond_flag}, 32'd0);
    apply(1, 0, 32'h0000_0000, 0, "R2 set bit0");
    apply(1, 0, 32'h0000_00F0, 31, "R2 set msb");
    apply(1, 0, 32'h0, 35, "R8 index 35 wraps to 3");
    apply(1, 1, 32'hFFFF_FFFF, 64 + 7, "R8 R3 clear wrapped");
    apply(1, 3, 32'h0, 5, "R5 put cond false");
    apply(1, 2, 32'h0000_0100, 8, "R4 get one");
    apply(1, 3, 32'h0, 5, "R5 put cond true");
    apply(1, 1, 32'h0, 4, "R9 clear keeps cond");
    apply(1, 2, 32'h0000_0100, 9, "R4 get zero");
    apply(1, 4, 32'h0, 0, "R6 zero of zero");
    apply(0, 4, 32'h5, 0, "R9 R10 invalid ignored");
    apply(1, 5, 32'h0, 0, "R6 nonzero of zero");
    apply(1, 6, 32'h1, 32'hFFFF_FFFF, "R7 unsigned carry");
    apply(1, 6, 32'h7, 32'h7, "R7 carry equal");
    apply(1, 7, 32'h7, 32'h7, "R7 nocarry equal");
    apply(1, 4'd9, 32'h0, 32'h1, "R9 R10 unused code");
    apply(1, 7, 32'h1, 32'h8000_0000, "R7 unsigned nocarry");
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] c;
      logic [W-1:0] a, b;
      c = ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom % 8);
      a = ($urandom % 6 == 0) ? '0 : $urandom;
      b = ($urandom % 2 == 0) ? ($urandom % 80) : $urandom;
      if ($urandom % 8 == 0) b = a;
      apply(($urandom % 10) != 0, c, a, b, tag_of(c));
    end
    @(negedge clk);
    check("R9 final cond", {31'd0, cond_flag}, {31'd0, m_cond});
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule